// File: doc/BRIEF.md
# SPI Slave Register Bank

This block is a serial-peripheral slave that gives an external master access to a bank of 16-bit registers. Every transfer is a fixed 16-bit frame, shifted most significant bit first. The master may keep chip select low across any number of back-to-back frames. The block counts SCK edges to find each frame boundary. It does not rely on chip select toggling between frames.

A frame that arrives while no write is in progress is a command. The top bit of a command chooses between write and read, and the low six bits name one of 64 registers. A write command is followed by one data frame, and that data is stored at the end of the data frame. A read command causes the named register to be shifted out on MISO during the very next frame. That next frame is itself decoded as a command, so a master can stream reads and receive each result one frame later. SCK, MOSI and chip select are brought into the system clock domain through a two-flop synchroniser. They are sampled there with an edge detector, which needs a system clock at least four times faster than SCK. Only SPI mode 0 is supported.

Top module: `spi_reg_bank`

## Requirements
- R1: Frames are 16 bits, MSB first. MOSI is captured on rising SCK. MISO changes only after falling SCK, or when a new response word is loaded at a frame boundary.
- R2: In a command frame, bit 15 = 1 means write and bit 15 = 0 means read.
- R3: Command bits [5:0] select one of 64 registers. Bits [14:6] have no effect on which register is accessed.
- R4: The frame after a write command is a data frame. At the end of that frame, its full 16-bit value is stored into the addressed register.
- R5: After a read command frame, the addressed register's value appears on MISO during the next frame. This is one frame of latency, not two.
- R6: The frame that follows a read command is decoded as a new command, so consecutive read commands return their results one frame apart.
- R7: MISO carries 0x0000 in any frame that has no pending read response. This includes the first frame after chip select falls, a data frame, and the frame after a write's data.
- R8: After reset, every register holds 0xBEEF, and MISO is 0.
- R9: Raising chip select aborts a partial frame, clears the bit count, and drops any pending write-data phase or read response. Completed writes are kept.
- R10: While chip select stays low, frames follow one another every 16 SCK edges with no gap required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock from master (idles low) |
| mosiIn | input | 1 | Serial data from master |
| ssNIn | input | 1 | Active-low chip select |
| misoOut | output | 1 | Serial data to master |

## Verification
On every cycle, the assertions check the following. Chip select high clears the bit count, the phase and the outgoing word. A completed frame restarts the count. A committed write lands in the named register. MISO holds still unless a falling SCK edge, a frame-boundary load or an idle clear occurs. The bench scenarios are needed to show that a read result arrives exactly one frame after its command and not two. They also show that streamed reads pipeline correctly, that the upper command bits are ignored, and that an aborted write or read leaves no trace in later frames.

// File: rtl/spi_reg_bank_pkg.sv
package spi_reg_bank_pkg;

  localparam int unsigned RB_DATA_W = 16;
  localparam int unsigned RB_DEPTH  = 64;

  typedef struct packed {
    logic shiftIn;     // capture MOSI on rising SCK
    logic shiftOut;    // advance MISO word on falling SCK
    logic loadRead;    // load addressed register for next frame
    logic loadZero;    // load idle word for next frame
    logic latchAddr;   // hold write address for data frame
    logic commitWrite; // store received data frame
    logic clearFrame;  // chip select high: flush frame state
  } rbStrobes_t;

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic mosiIn,
  input  logic ssNIn,
  output logic sckRise,
  output logic sckFall,
  output logic mosiS,
  output logic ssIdle
);

  localparam int unsigned NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b100; // {ssN, mosi, sck}

  logic [NSIG-1:0] stage [STAGES];
  logic sckPrev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= {ssNIn, mosiIn, sckIn};
        else stage[g] <= stage[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else sckPrev <= stage[STAGES-1][0];
  end

  assign sckRise = stage[STAGES-1][0] & ~sckPrev;
  assign sckFall = ~stage[STAGES-1][0] & sckPrev;
  assign mosiS   = stage[STAGES-1][1];
  assign ssIdle  = stage[STAGES-1][2];

endmodule

// File: rtl/spi_rb_ctrl.sv
module spi_rb_ctrl
  import spi_reg_bank_pkg::*;
#(
  parameter int unsigned FRAME_BITS = RB_DATA_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       ssIdle,
  input  logic       cmdIsWrite,
  output rbStrobes_t strb
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  phase_t phase, phaseNext;
  logic [CNT_W-1:0] bitCnt;
  logic rise, fall, lastBit, frameDone;

  assign rise      = sckRise & ~ssIdle;
  assign fall      = sckFall & ~ssIdle;
  assign lastBit   = (bitCnt == LAST);
  assign frameDone = rise & lastBit;

  always_comb begin
    strb             = '0;
    phaseNext        = phase;
    strb.clearFrame  = ssIdle;
    strb.shiftIn     = rise;
    strb.shiftOut    = fall && (bitCnt != '0);
    if (ssIdle) begin
      phaseNext = PH_CMD;
    end else if (frameDone) begin
      if (phase == PH_DATA) begin
        strb.commitWrite = 1'b1;
        strb.loadZero    = 1'b1;
        phaseNext        = PH_CMD;
      end else if (cmdIsWrite) begin
        strb.latchAddr = 1'b1;
        strb.loadZero  = 1'b1;
        phaseNext      = PH_DATA;
      end else begin
        strb.loadRead = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      phase  <= PH_CMD;
    end else begin
      phase <= phaseNext;
      if (ssIdle) bitCnt <= '0;
      else if (rise) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    ssIdle |=> (bitCnt == '0)); // R9

  AST_IDLE_DROPS_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    ssIdle |=> (phase == PH_CMD)); // R9

  AST_FRAME_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite || strb.loadRead || strb.latchAddr) |=> (bitCnt == '0)); // R10

  AST_WRITE_THEN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchAddr |=> (phase == PH_DATA)); // R4

endmodule

// File: rtl/spi_rb_datapath.sv
module spi_rb_datapath
  import spi_reg_bank_pkg::*;
#(
  parameter int unsigned DATA_W    = RB_DATA_W,
  parameter int unsigned DEPTH     = RB_DEPTH,
  parameter logic [DATA_W-1:0] RESET_VAL = 16'hBEEF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mosiS,
  input  rbStrobes_t strb,
  output logic       cmdIsWrite,
  output logic       misoOut
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] rxShift, txShift, rxWord;
  logic [DATA_W-1:0] bank [DEPTH];
  logic [ADDR_W-1:0] cmdAddr, wAddr;

  assign rxWord     = {rxShift[DATA_W-2:0], mosiS};
  assign cmdAddr    = rxWord[ADDR_W-1:0];
  assign cmdIsWrite = rxWord[DATA_W-1];
  assign misoOut    = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      wAddr   <= '0;
      for (int i = 0; i < DEPTH; i++) bank[i] <= RESET_VAL;
    end else begin
      if (strb.clearFrame) begin
        rxShift <= '0;
        txShift <= '0;
      end else begin
        if (strb.shiftIn) rxShift <= rxWord;
        if (strb.loadRead) txShift <= bank[cmdAddr];
        else if (strb.loadZero) txShift <= '0;
        else if (strb.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (strb.latchAddr) wAddr <= cmdAddr;
      if (strb.commitWrite) bank[wAddr] <= rxWord;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |=> (bank[$past(wAddr)] == $past(rxWord))); // R4

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftOut || strb.loadRead || strb.loadZero || strb.clearFrame)
      |=> $stable(misoOut)); // R1

  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearFrame |=> !misoOut); // R7

  AST_READ_LOADS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRead |=> (txShift == bank[$past(cmdAddr)])); // R5

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_bank_pkg::*;
#(
  parameter int unsigned DATA_W = RB_DATA_W,
  parameter int unsigned DEPTH  = RB_DEPTH,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic mosiIn,
  input  logic ssNIn,
  output logic misoOut
);

  logic sckRise, sckFall, mosiS, ssIdle, cmdIsWrite;
  rbStrobes_t strb;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .ssNIn(ssNIn),
    .sckRise(sckRise), .sckFall(sckFall), .mosiS(mosiS), .ssIdle(ssIdle)
  );

  spi_rb_ctrl #(.FRAME_BITS(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .ssIdle(ssIdle), .cmdIsWrite(cmdIsWrite), .strb(strb)
  );

  spi_rb_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .mosiS(mosiS), .strb(strb),
    .cmdIsWrite(cmdIsWrite), .misoOut(misoOut)
  );

endmodule

// File: tb/spi_reg_bank_bench.sv
module spi_reg_bank_bench;

  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, mosi = 1'b0, ssN = 1'b1;
  logic miso;

  always #10 clk = ~clk;

  spi_reg_bank u_spi_reg_bank (
    .clk(clk), .rstN(rstN), .sckIn(sck), .mosiIn(mosi), .ssNIn(ssN), .misoOut(miso)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$], actQ[$];
  string tagQ[$];

  logic [15:0] mBank [64];
  bit mPhase;
  logic [5:0] mAddr;
  logic [15:0] mTx;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modelIdle();
    mPhase = 1'b0;
    mTx = 16'h0000;
  endtask

  task automatic selectOn();
    ssN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic selectOff();
    waitClk(HALF);
    ssN = 1'b1;
    waitClk(4 * HALF);
    modelIdle();
  endtask

  task automatic frame(input logic [15:0] w, input string tag);
    logic [15:0] cap;
    expQ.push_back(mTx);
    tagQ.push_back(tag);
    if (mPhase) begin
      mBank[mAddr] = w;
      mPhase = 1'b0;
      mTx = 16'h0000;
    end else if (w[15]) begin
      mAddr = w[5:0];
      mPhase = 1'b1;
      mTx = 16'h0000;
    end else begin
      mTx = mBank[w[5:0]];
    end
    for (int i = 15; i >= 0; i--) begin
      mosi = w[i];
      waitClk(HALF);
      cap[i] = miso;
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
    actQ.push_back(cap);
  endtask

  task automatic partial(input logic [15:0] w, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = w[i];
      waitClk(HALF);
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (actQ.size() > 0) begin
        logic [15:0] a, e;
        string t;
        a = actQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: miso word actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 64; i++) mBank[i] = 16'hBEEF;
    modelIdle();
    mAddr = '0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    checks++;
    if (miso !== 1'b0) begin
      fails++;
      $display("FAIL R8: reset miso actual %b expected 0", miso);
    end

    // R8 R5 R7: reset contents read with one-frame latency; first frame idle
    selectOn();
    frame(16'h0005, "R7 first frame");
    frame(16'h0000, "R8 R5 reset value");
    selectOff();

    // R2 R4 R10: write then read back on the next frame, select held low
    selectOn();
    frame(16'h8005, "R2 write cmd");
    frame(16'h8009, "R7 data frame");
    frame(16'h0005, "R7 after write");
    frame(16'h0007, "R5 one-frame latency");
    frame(16'h0000, "R6 R10 pipelined");
    // R6: streamed reads
    frame(16'h0005, "R6 stream");
    frame(16'h0007, "R6 stream a");
    frame(16'h0005, "R6 stream b");
    frame(16'h0000, "R6 stream c");
    // R3: upper bits ignored, boundary addresses
    frame(16'h8043, "R3 write addr3");
    frame(16'h1234, "R4 data");
    frame(16'h7FC3, "R3 read ignores 14:6");
    frame(16'h803F, "R3 write addr63");
    frame(16'hA5A5, "R4 data 63");
    frame(16'h003F, "R3 read 63");
    frame(16'h0000, "R3 read 0");
    frame(16'h0000, "R1 MSB first");
    selectOff();

    // R9: write aborted between command and data
    selectOn();
    frame(16'h8002, "R9 write cmd");
    selectOff();
    selectOn();
    frame(16'h0001, "R9 phase dropped");
    frame(16'h0002, "R9 addr2 untouched");
    frame(16'h0000, "R9 addr2 value");
    selectOff();

    // R9: partial frame abort, and pending read dropped
    selectOn();
    partial(16'h8005, 7);
    selectOff();
    selectOn();
    frame(16'h0005, "R9 after partial");
    frame(16'h0000, "R9 kept write");
    frame(16'h0005, "R9 read then abort");
    selectOff();
    selectOn();
    frame(16'h0000, "R9 response dropped");
    selectOff();

    waitClk(10);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule